// File: doc/BRIEF.md
# Pixel-Clock PLL Divider Search Engine

This block picks the feedback, input and post divider settings of a pixel-clock PLL for a requested pixel frequency given in kHz. The reference is fixed at 48000 kHz. Each candidate yields the frequency 48000·n / (m·p), using truncating integer division. After a start pulse the engine walks every candidate in a fixed order. It drops a whole post-divider value when the implied oscillator frequency falls outside its legal window. It keeps the candidate whose absolute error against the request is smallest.

Each candidate's quotient comes from a sequential restoring divider that retires several quotient bits per cycle. Once the walk ends, the chosen raw values are presented with a fixed zero spread field. The same values are also packed into three 8-bit register images ready for a PLL programming sequencer. A one-cycle done pulse marks the point where the new results are valid. The results then hold until the next search completes.

Top module: `pll_div_search`

## Requirements
- R1: After reset, busy_o and done_o are 0, div_n_o, div_m_o, div_p_o and div_s_o are 0, and all three packed bytes read 0xFF.
- R2: A start_i sampled high while idle latches req_khz_i. busy_o is high from the next cycle until the search ends. done_o is then high for exactly one cycle with busy_o low, and busy_o never rises without a start.
- R3: Each candidate frequency is floor(48000·n / (m·p)). The reported (n, m, p) minimises |frequency − request| over n in 1..150, m in 1..16 and p in 1..8.
- R4: A post-divider value p is considered only when 150000 ≤ request·p ≤ 550000, with both bounds inclusive.
- R5: Candidates are visited with p outermost, then m, then n innermost, each ascending. A candidate replaces the stored best only on a strictly smaller error, so on a tie the earliest one wins.
- R6: When no p passes the window, div_n_o, div_m_o and div_p_o are 0 and every packed byte is 0xFF. The packed bytes follow from R7 and R8 with 11-bit wrapping of n−1 and 8-bit wrapping of m−1 and p−1.
- R7: reg_m_o equals (bit 8 of (n−1)) placed at bit 7, OR-ed with (m−1).
- R8: reg_n_o equals bits 7:0 of (n−1). reg_p_o equals bits 10:9 of (n−1) at bits 7:6, OR-ed with the spread value at bits 5:3, OR-ed with (p−1).
- R9: div_s_o (the spread value) is always 0.
- R10: A start_i pulse while busy_o is high is ignored, so the result belongs to the request latched at the accepted start.
- R11: div_n_o, div_m_o, div_p_o and the packed bytes change only in the cycle where done_o is high. They hold their previous values throughout a later search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| req_khz_i | input | REQ_W | Requested pixel frequency in kHz |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle pulse when results become valid |
| div_n_o | output | clog2(N_MAX+1) | Chosen feedback divider n |
| div_m_o | output | clog2(M_MAX+1) | Chosen input divider m |
| div_p_o | output | clog2(P_MAX+1) | Chosen post divider p |
| div_s_o | output | 3 | Spread value, always 0 |
| reg_n_o | output | 8 | Packed N register image |
| reg_m_o | output | 8 | Packed M register image |
| reg_p_o | output | 8 | Packed P register image |

## Verification
The bench runs a reference search over all candidates and compares every result field and packed byte. It targets requests sitting exactly on the 150000 and 550000 window bounds. A design using strict comparisons would skip a legal post divider there and report a different triple. Requests with no legal post divider check that the outputs stay zero and the bytes read 0xFF; a design that defaulted the encodings to zero would show 0x00. A start pulse mid-search and output sampling during a later search expose a restart on a busy start, or results that leak before done. A non-strict replacement rule shows up as a later, equal-error triple on requests where ties occur.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

    localparam int unsigned REF_KHZ     = 48000;
    localparam int unsigned VCO_MIN_KHZ = 150000;
    localparam int unsigned VCO_MAX_KHZ = 550000;
    localparam int unsigned ERR_W       = 32;
    localparam int unsigned SPREAD_W    = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PCHK,
        ST_ISSUE,
        ST_WAIT,
        ST_FLUSH,
        ST_DONE
    } srch_state_e;

    typedef struct packed {
        logic [7:0] reg_m;
        logic [7:0] reg_n;
        logic [7:0] reg_p;
    } pll_regs_t;

    // Scatter the encoded divider fields into the three register images.
    function automatic pll_regs_t pack_regs(input logic [10:0] n_enc,
                                            input logic [7:0]  m_enc,
                                            input logic [7:0]  p_enc,
                                            input logic [SPREAD_W-1:0] s_val);
        pll_regs_t r;
        r.reg_m = {n_enc[8], 7'd0} | m_enc;
        r.reg_n = n_enc[7:0];
        r.reg_p = {n_enc[10:9], 6'd0} | {2'd0, s_val, 3'd0} | p_enc;
        return r;
    endfunction

endpackage

// File: rtl/pll_div_restoring.sv
module pll_div_restoring #(
    parameter int unsigned NUM_W = 23,
    parameter int unsigned DEN_W = 8,
    parameter int unsigned STEP  = 12,
    parameter int unsigned OUT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             done_o,
    output logic [OUT_W-1:0] quo_o
);
    localparam int unsigned CYC   = (NUM_W + STEP - 1) / STEP;
    localparam int unsigned TOT   = CYC * STEP;
    localparam int unsigned CNT_W = $clog2(CYC + 1);

    logic [TOT-1:0]   sh_q, sh_n;
    logic [DEN_W:0]   rem_q, rem_n;
    logic [DEN_W-1:0] den_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;

    // STEP restoring iterations per clock.
    always_comb begin
        sh_n  = sh_q;
        rem_n = rem_q;
        for (int i = 0; i < STEP; i++) begin
            rem_n = {rem_n[DEN_W-1:0], sh_n[TOT-1]};
            sh_n  = {sh_n[TOT-2:0], 1'b0};
            if (rem_n >= {1'b0, den_q}) begin
                rem_n    = rem_n - {1'b0, den_q};
                sh_n[0]  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            rem_q  <= '0;
            den_q  <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (start_i) begin
            sh_q   <= TOT'(num_i);
            rem_q  <= '0;
            den_q  <= den_i;
            cnt_q  <= CNT_W'(CYC);
            done_q <= 1'b0;
        end else if (cnt_q != '0) begin
            sh_q   <= sh_n;
            rem_q  <= rem_n;
            cnt_q  <= cnt_q - CNT_W'(1);
            done_q <= (cnt_q == CNT_W'(1));
        end else begin
            done_q <= 1'b0;
        end
    end

    assign done_o = done_q;
    assign quo_o  = OUT_W'(sh_q);

endmodule

// File: rtl/pll_best_keeper.sv
module pll_best_keeper #(
    parameter int unsigned ERR_W = 32,
    parameter int unsigned REQ_W = 20,
    parameter int unsigned P_W   = 4,
    parameter int unsigned M_W   = 5,
    parameter int unsigned N_W   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             upd_i,
    input  logic [ERR_W-1:0] quo_i,
    input  logic [REQ_W-1:0] req_i,
    input  logic [P_W-1:0]   cand_p_i,
    input  logic [M_W-1:0]   cand_m_i,
    input  logic [N_W-1:0]   cand_n_i,
    output logic [P_W-1:0]   best_p_o,
    output logic [M_W-1:0]   best_m_o,
    output logic [N_W-1:0]   best_n_o
);
    logic [ERR_W-1:0] req_ext, err, best_err_q;

    assign req_ext = ERR_W'(req_i);
    assign err     = (quo_i > req_ext) ? (quo_i - req_ext) : (req_ext - quo_i);

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            best_err_q <= '1;
            best_p_o   <= '0;
            best_m_o   <= '0;
            best_n_o   <= '0;
        end else if (upd_i && (err < best_err_q)) begin
            best_err_q <= err;
            best_p_o   <= cand_p_i;
            best_m_o   <= cand_m_i;
            best_n_o   <= cand_n_i;
        end
    end

endmodule

// File: rtl/pll_reg_packer.sv
module pll_reg_packer
    import pll_search_pkg::*;
#(
    parameter int unsigned P_W = 4,
    parameter int unsigned M_W = 5,
    parameter int unsigned N_W = 8
) (
    input  logic [P_W-1:0]      p_i,
    input  logic [M_W-1:0]      m_i,
    input  logic [N_W-1:0]      n_i,
    input  logic [SPREAD_W-1:0] s_i,
    output logic [7:0]          reg_m_o,
    output logic [7:0]          reg_n_o,
    output logic [7:0]          reg_p_o
);
    logic [10:0] n_enc;
    logic [7:0]  m_enc, p_enc;
    pll_regs_t   regs;

    assign n_enc   = 11'(n_i) - 11'd1;
    assign m_enc   = 8'(m_i) - 8'd1;
    assign p_enc   = 8'(p_i) - 8'd1;
    assign regs    = pack_regs(n_enc, m_enc, p_enc, s_i);
    assign reg_m_o = regs.reg_m;
    assign reg_n_o = regs.reg_n;
    assign reg_p_o = regs.reg_p;

endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
    import pll_search_pkg::*;
#(
    parameter int unsigned REQ_W    = 20,
    parameter int unsigned P_MAX    = 8,
    parameter int unsigned M_MAX    = 16,
    parameter int unsigned N_MAX    = 150,
    parameter int unsigned DIV_STEP = 12
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start_i,
    input  logic [REQ_W-1:0]             req_khz_i,
    output logic                         busy_o,
    output logic                         done_o,
    output logic [$clog2(N_MAX+1)-1:0]   div_n_o,
    output logic [$clog2(M_MAX+1)-1:0]   div_m_o,
    output logic [$clog2(P_MAX+1)-1:0]   div_p_o,
    output logic [2:0]                   div_s_o,
    output logic [7:0]                   reg_n_o,
    output logic [7:0]                   reg_m_o,
    output logic [7:0]                   reg_p_o
);
    localparam int unsigned P_W    = $clog2(P_MAX + 1);
    localparam int unsigned M_W    = $clog2(M_MAX + 1);
    localparam int unsigned N_W    = $clog2(N_MAX + 1);
    localparam int unsigned NUM_W  = $clog2(REF_KHZ * N_MAX + 1);
    localparam int unsigned DEN_W  = $clog2(P_MAX * M_MAX + 1);
    localparam int unsigned PROD_W = REQ_W + P_W;

    srch_state_e      state_q;
    logic [REQ_W-1:0] req_q;
    logic [P_W-1:0]   p_q, best_p, out_p_q;
    logic [M_W-1:0]   m_q, best_m, out_m_q;
    logic [N_W-1:0]   n_q, best_n, out_n_q;

    logic [PROD_W-1:0] vco;
    logic              in_win, last_p, last_m, last_n;
    logic              div_start, div_done, keep_clear, keep_upd;
    logic [NUM_W-1:0]  div_num;
    logic [DEN_W-1:0]  div_den;
    logic [ERR_W-1:0]  div_quo;

    assign vco    = PROD_W'(req_q) * PROD_W'(p_q);
    assign in_win = (vco >= PROD_W'(VCO_MIN_KHZ)) && (vco <= PROD_W'(VCO_MAX_KHZ));
    assign last_p = (p_q == P_W'(P_MAX));
    assign last_m = (m_q == M_W'(M_MAX));
    assign last_n = (n_q == N_W'(N_MAX));

    assign div_start  = (state_q == ST_ISSUE);
    assign div_num    = NUM_W'(REF_KHZ * 32'(n_q));
    assign div_den    = DEN_W'(32'(m_q) * 32'(p_q));
    assign keep_clear = (state_q == ST_IDLE) && start_i;
    assign keep_upd   = (state_q == ST_WAIT) && div_done;

    pll_div_restoring #(
        .NUM_W (NUM_W),
        .DEN_W (DEN_W),
        .STEP  (DIV_STEP),
        .OUT_W (ERR_W)
    ) u_div (
        .clk     (clk),
        .rst     (rst),
        .start_i (div_start),
        .num_i   (div_num),
        .den_i   (div_den),
        .done_o  (div_done),
        .quo_o   (div_quo)
    );

    pll_best_keeper #(
        .ERR_W (ERR_W),
        .REQ_W (REQ_W),
        .P_W   (P_W),
        .M_W   (M_W),
        .N_W   (N_W)
    ) u_keep (
        .clk      (clk),
        .rst      (rst),
        .clear_i  (keep_clear),
        .upd_i    (keep_upd),
        .quo_i    (div_quo),
        .req_i    (req_q),
        .cand_p_i (p_q),
        .cand_m_i (m_q),
        .cand_n_i (n_q),
        .best_p_o (best_p),
        .best_m_o (best_m),
        .best_n_o (best_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
            p_q     <= '0;
            m_q     <= '0;
            n_q     <= '0;
            out_p_q <= '0;
            out_m_q <= '0;
            out_n_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        req_q   <= req_khz_i;
                        p_q     <= P_W'(1);
                        m_q     <= M_W'(1);
                        n_q     <= N_W'(1);
                        state_q <= ST_PCHK;
                    end
                end
                ST_PCHK: begin
                    if (in_win) begin
                        state_q <= ST_ISSUE;
                    end else if (last_p) begin
                        state_q <= ST_FLUSH;
                    end else begin
                        p_q <= p_q + P_W'(1);
                    end
                end
                ST_ISSUE: begin
                    state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (div_done) begin
                        if (!last_n) begin
                            n_q     <= n_q + N_W'(1);
                            state_q <= ST_ISSUE;
                        end else begin
                            n_q <= N_W'(1);
                            if (!last_m) begin
                                m_q     <= m_q + M_W'(1);
                                state_q <= ST_ISSUE;
                            end else begin
                                m_q <= M_W'(1);
                                if (last_p) begin
                                    state_q <= ST_FLUSH;
                                end else begin
                                    p_q     <= p_q + P_W'(1);
                                    state_q <= ST_PCHK;
                                end
                            end
                        end
                    end
                end
                ST_FLUSH: begin
                    out_p_q <= best_p;
                    out_m_q <= best_m;
                    out_n_q <= best_n;
                    state_q <= ST_DONE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign busy_o  = (state_q != ST_IDLE) && (state_q != ST_DONE);
    assign done_o  = (state_q == ST_DONE);
    assign div_n_o = out_n_q;
    assign div_m_o = out_m_q;
    assign div_p_o = out_p_q;
    assign div_s_o = '0;

    pll_reg_packer #(
        .P_W (P_W),
        .M_W (M_W),
        .N_W (N_W)
    ) u_pack (
        .p_i     (out_p_q),
        .m_i     (out_m_q),
        .n_i     (out_n_q),
        .s_i     (div_s_o),
        .reg_m_o (reg_m_o),
        .reg_n_o (reg_n_o),
        .reg_p_o (reg_p_o)
    );

endmodule

// File: rtl/pll_div_search_chk.sv
module pll_div_search_chk
    import pll_search_pkg::*;
#(
    parameter int unsigned REQ_W = 20,
    parameter int unsigned P_MAX = 8,
    parameter int unsigned M_MAX = 16,
    parameter int unsigned N_MAX = 150
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       start_i,
    input logic                       busy_o,
    input logic                       done_o,
    input logic [$clog2(N_MAX+1)-1:0] div_n_o,
    input logic [$clog2(M_MAX+1)-1:0] div_m_o,
    input logic [$clog2(P_MAX+1)-1:0] div_p_o,
    input logic [7:0]                 reg_n_o,
    input logic [7:0]                 reg_m_o,
    input logic [7:0]                 reg_p_o,
    input logic [REQ_W-1:0]           req_q
);
    logic [63:0] vco_chk;
    assign vco_chk = 64'(req_q) * 64'(div_p_o);

    // R2
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy_o && done_o));

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R2
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));

    // R11
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable({div_n_o, div_m_o, div_p_o, reg_n_o, reg_m_o, reg_p_o}) |-> done_o);

    // R4
    vco_window_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && div_p_o != '0) |-> (vco_chk >= 64'(VCO_MIN_KHZ) && vco_chk <= 64'(VCO_MAX_KHZ)));

    // R3
    cand_range_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && div_p_o != '0) |-> (div_m_o >= 1 && 32'(div_m_o) <= M_MAX &&
                                       div_n_o >= 1 && 32'(div_n_o) <= N_MAX &&
                                       32'(div_p_o) <= P_MAX));

    // R6
    none_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && div_p_o == '0) |-> (div_m_o == '0 && div_n_o == '0 && reg_n_o == 8'hFF));

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> $stable(req_q));

endmodule

bind pll_div_search pll_div_search_chk #(
    .REQ_W (REQ_W),
    .P_MAX (P_MAX),
    .M_MAX (M_MAX),
    .N_MAX (N_MAX)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .div_n_o (div_n_o),
    .div_m_o (div_m_o),
    .div_p_o (div_p_o),
    .reg_n_o (reg_n_o),
    .reg_m_o (reg_m_o),
    .reg_p_o (reg_p_o),
    .req_q   (req_q)
);

// File: tb/pll_div_search_tb.sv
module pll_div_search_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [19:0] req_khz_i;
    logic        busy_o, done_o;
    logic [7:0]  div_n_o;
    logic [4:0]  div_m_o;
    logic [3:0]  div_p_o;
    logic [2:0]  div_s_o;
    logic [7:0]  reg_n_o, reg_m_o, reg_p_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pll_div_search u_dut (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .req_khz_i (req_khz_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .div_n_o   (div_n_o),
        .div_m_o   (div_m_o),
        .div_p_o   (div_p_o),
        .div_s_o   (div_s_o),
        .reg_n_o   (reg_n_o),
        .reg_m_o   (reg_m_o),
        .reg_p_o   (reg_p_o)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic void ref_search(input longint req, output int bn, output int bm, output int bp);
        longint best = 64'hFFFF_FFFF;
        bn = 0; bm = 0; bp = 0;
        for (int p = 1; p <= 8; p++) begin
            if (req * p > 550000 || req * p < 150000) continue;
            for (int m = 1; m <= 16; m++) begin
                for (int n = 1; n <= 150; n++) begin
                    longint c = (longint'(48000) * n) / (m * p);
                    longint d = (c > req) ? c - req : req - c;
                    if (d < best) begin
                        best = d; bn = n; bm = m; bp = p;
                    end
                end
            end
        end
    endfunction

    task automatic check_result(input string tag, input longint req);
        int en, em, ep, nm1, mm1, pm1;
        ref_search(req, en, em, ep);
        nm1 = (en - 1) & 'h7FF;
        mm1 = (em - 1) & 'hFF;
        pm1 = (ep - 1) & 'hFF;
        chk({tag, " R3 R5 n"}, div_n_o, en);
        chk({tag, " R3 R5 m"}, div_m_o, em);
        chk({tag, " R3 R5 p"}, div_p_o, ep);
        chk({tag, " R9 s"}, div_s_o, 0);
        chk({tag, " R7 reg_m"}, reg_m_o, ((((nm1 >> 8) & 1) << 7) | mm1) & 'hFF);
        chk({tag, " R8 reg_n"}, reg_n_o, nm1 & 'hFF);
        chk({tag, " R8 reg_p"}, reg_p_o, ((((nm1 >> 9) & 3) << 6) | pm1) & 'hFF);
    endtask

    task automatic kick(input longint req);
        @(negedge clk);
        req_khz_i = 20'(req);
        start_i   = 1'b1;
        @(negedge clk);
        start_i   = 1'b0;
        chk("R2 busy after start", busy_o, 1);
    endtask

    task automatic wait_done();
        int cnt = 0;
        while (!done_o && cnt < 40000) begin
            @(negedge clk);
            cnt++;
        end
        chk("R2 done reached", done_o, 1);
        chk("R2 not busy at done", busy_o, 0);
    endtask

    task automatic run_case(input string tag, input longint req);
        kick(req);
        wait_done();
        check_result(tag, req);
        @(negedge clk);
        chk("R2 done single cycle", done_o, 0);
    endtask

    initial begin
        #(8 * 190000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] h_n, h_rn, h_rm, h_rp;
        logic [4:0] h_m;
        logic [3:0] h_p;
        rst = 1'b1;
        start_i = 1'b0;
        req_khz_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy_o, 0);
        chk("R1 done", done_o, 0);
        chk("R1 n", div_n_o, 0);
        chk("R1 m", div_m_o, 0);
        chk("R1 p", div_p_o, 0);
        chk("R1 reg_m", reg_m_o, 'hFF);
        chk("R1 reg_n", reg_n_o, 'hFF);
        chk("R1 reg_p", reg_p_o, 'hFF);

        run_case("single p", 500000);
        run_case("R4 lower bound", 150000);
        run_case("R4 upper bound", 550000);
        run_case("R6 above window", 550001);
        run_case("R6 below window", 10000);

        void'($urandom(32'd1234));
        for (int k = 0; k < 3; k++) begin
            longint r = 275001 + ($urandom % 275000);
            run_case("random", r);
        end

        // R11: results hold during a later search
        h_n = div_n_o; h_m = div_m_o; h_p = div_p_o;
        h_rn = reg_n_o; h_rm = reg_m_o; h_rp = reg_p_o;
        kick(140000);
        repeat (200) @(negedge clk);
        chk("R11 n held", div_n_o, h_n);
        chk("R11 m held", div_m_o, h_m);
        chk("R11 p held", div_p_o, h_p);
        chk("R11 reg_n held", reg_n_o, h_rn);
        chk("R11 reg_m held", reg_m_o, h_rm);
        chk("R11 reg_p held", reg_p_o, h_rp);
        wait_done();
        check_result("two p", 140000);

        // R10: a start while busy is ignored
        kick(400000);
        repeat (50) @(negedge clk);
        req_khz_i = 20'd60000;
        start_i   = 1'b1;
        @(negedge clk);
        start_i   = 1'b0;
        chk("R10 still busy", busy_o, 1);
        wait_done();
        check_result("R10 busy start", 400000);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule